// File: doc/BRIEF.md
# Dual-Channel UART Host Register Bank

This block is the host-side register file of a two-channel serial controller. A host bus with a 3-bit address, an 8-bit write bus, read and write strobes and a channel-select input reaches two identical register sets, one per channel. Each channel has a line-control register. Its top bit remaps the two lowest addresses from the data registers to the baud divisor bytes, and remaps address 2 from an auxiliary register to the shared alternate-function register.

The alternate-function register is a single copy that both channels share. Its concurrent-write bit makes one host write land in the addressed register of both channels at once, which halves the time needed to bring both channels to the same setup. Reads always follow the channel select. The same register also picks which internal active-low signal drives both channels' multifunction output pins. The modem-control register drives the inverted DTR and RTS lines. The serial datapath that uses these registers is not part of this block.

Top module: `dual_uart_regbank`

## Requirements
- R1: After reset all stored registers are 0. `rdData` is 0, `dtrN` and `rtsN` are both 2'b11, and `mfOut` follows `op2N`.
- R2: While concurrent write is off, a write changes only the channel chosen by `chSel` (0 = channel A, 1 = channel B).
- R3: While alternate-function bit 0 is 1, one write updates the addressed register in both channels.
- R4: The concurrent-write bit can be set or cleared by a write to address 2 through either channel, provided that channel's line-control bit 7 is 1.
- R5: While concurrent write is on, reads still return only the register of the channel chosen by `chSel`.
- R6: The address map depends on line-control bit 7. When it is 0, address 0 is the hold register, address 1 is the enable register and address 2 is the auxiliary register. When it is 1, these addresses are divisor low, divisor high and the alternate-function register. Address 3 is line control and address 4 is modem control in both cases.
- R7: During a concurrent write, each channel decodes addresses 0 to 2 with its own line-control bit 7. A mismatch between the two channels is left as it is.
- R8: Alternate-function bits 2:1 select the source for `mfOut`: 00 = `op2N`, 01 = `baudOutN`, 10 = `rxRdyN`, 11 = constant 1 (inactive).
- R9: Alternate-function bits 7:3 read as 0, and writes to them are ignored.
- R10: Modem-control bit 0 drives `dtrN` and bit 1 drives `rtsN`, both inverted. Writing a 1 drives the pin to 0.
- R11: `rdData` loads the addressed value at the clock edge that samples `rdEn` and holds it otherwise. A read in the same cycle as a write returns the old value. Addresses 5 to 7 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chSel | input | 1 | Channel select: 0 = A, 1 = B |
| addr | input | 3 | Register address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| op2N | input | 2 | Per-channel general output source, bit 0 = A |
| baudOutN | input | 2 | Per-channel baud clock source |
| rxRdyN | input | 2 | Per-channel receive-ready source |
| mfOut | output | 2 | Per-channel multifunction pin |
| dtrN | output | 2 | Per-channel DTR, active low |
| rtsN | output | 2 | Per-channel RTS, active low |
| lineCtrl | output | 16 | Line-control registers, A in [7:0] |
| divisor | output | 32 | Divisors {high, low}, A in [15:0] |
| holdReg | output | 16 | Hold registers, A in [7:0] |
| enableReg | output | 16 | Enable registers, A in [7:0] |
| auxReg | output | 16 | Auxiliary registers, A in [7:0] |

## Verification
A host read and a concurrent write can fall in the same cycle, and both can target the same register. The bench asserts both strobes on one edge with concurrent write off and then with it on, with `chSel` pointing at channel B. It expects `rdData` to show that channel's value from before the write. A follow-up read must then show the new value in both channels. A second case combines a concurrent write with differing line-control bit 7 in the two channels. It is judged by reading each channel afterwards to see which register each one took.

// File: rtl/dual_uart_regbank_pkg.sv
package dual_uart_regbank_pkg;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_LOW  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_HIGH = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_ALT  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_LINE = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_MDM  = 3'd4;

  localparam logic [1:0] MF_OP2  = 2'b00;
  localparam logic [1:0] MF_BAUD = 2'b01;
  localparam logic [1:0] MF_RXRDY = 2'b10;

  typedef enum logic [3:0] {
    RD_NONE, RD_HOLD, RD_ENABLE, RD_AUX, RD_DIVLO, RD_DIVHI,
    RD_ALT, RD_LINE, RD_MDM
  } rdSelT;

  typedef struct packed {
    logic [NUM_CH-1:0] wrHold;
    logic [NUM_CH-1:0] wrEnable;
    logic [NUM_CH-1:0] wrAux;
    logic [NUM_CH-1:0] wrDivLo;
    logic [NUM_CH-1:0] wrDivHi;
    logic [NUM_CH-1:0] wrLine;
    logic [NUM_CH-1:0] wrMdm;
    logic              wrAlt;
    logic              rdStb;
    logic              rdCh;
    rdSelT             rdSel;
  } strobeT;
endpackage

// File: rtl/dual_uart_regbank_ctrl.sv
module dual_uart_regbank_ctrl
  import dual_uart_regbank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              chSel,
  input  logic              concWr,
  input  logic [NUM_CH-1:0] dlab,
  output strobeT            strb
);
  always_comb begin
    strb = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (wrEn && (concWr || (chSel == 1'(ch)))) begin
        unique case (addr)
          ADDR_LOW:  if (dlab[ch]) strb.wrDivLo[ch] = 1'b1; else strb.wrHold[ch] = 1'b1;
          ADDR_HIGH: if (dlab[ch]) strb.wrDivHi[ch] = 1'b1; else strb.wrEnable[ch] = 1'b1;
          ADDR_ALT:  if (dlab[ch]) strb.wrAlt = 1'b1; else strb.wrAux[ch] = 1'b1;
          ADDR_LINE: strb.wrLine[ch] = 1'b1;
          ADDR_MDM:  strb.wrMdm[ch] = 1'b1;
          default:   ;
        endcase
      end
    end
    strb.rdStb = rdEn;
    strb.rdCh  = chSel;
    unique case (addr)
      ADDR_LOW:  strb.rdSel = dlab[chSel] ? RD_DIVLO : RD_HOLD;
      ADDR_HIGH: strb.rdSel = dlab[chSel] ? RD_DIVHI : RD_ENABLE;
      ADDR_ALT:  strb.rdSel = dlab[chSel] ? RD_ALT : RD_AUX;
      ADDR_LINE: strb.rdSel = RD_LINE;
      ADDR_MDM:  strb.rdSel = RD_MDM;
      default:   strb.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/dual_uart_regbank_dp.sv
module dual_uart_regbank_dp
  import dual_uart_regbank_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               strb,
  input  logic [DW-1:0]        wrData,
  input  logic [NUM_CH-1:0]    op2N,
  input  logic [NUM_CH-1:0]    baudOutN,
  input  logic [NUM_CH-1:0]    rxRdyN,
  output logic [DW-1:0]        rdData,
  output logic [NUM_CH-1:0]    mfOut,
  output logic [NUM_CH-1:0]    dtrN,
  output logic [NUM_CH-1:0]    rtsN,
  output logic [NUM_CH*DW-1:0] lineCtrl,
  output logic [NUM_CH*2*DW-1:0] divisor,
  output logic [NUM_CH*DW-1:0] holdReg,
  output logic [NUM_CH*DW-1:0] enableReg,
  output logic [NUM_CH*DW-1:0] auxReg,
  output logic                 concWr,
  output logic [1:0]           mfSel,
  output logic [NUM_CH-1:0]    dlab
);
  localparam int ALT_W = 3;

  logic [ALT_W-1:0] altQ;
  logic [DW-1:0] holdQ [NUM_CH];
  logic [DW-1:0] enQ   [NUM_CH];
  logic [DW-1:0] auxQ  [NUM_CH];
  logic [DW-1:0] dlQ   [NUM_CH];
  logic [DW-1:0] dhQ   [NUM_CH];
  logic [DW-1:0] lineQ [NUM_CH];
  logic [DW-1:0] mdmQ  [NUM_CH];
  logic [DW-1:0] rdMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          altQ <= '0;
    else if (strb.wrAlt) altQ <= wrData[ALT_W-1:0];
  end

  assign concWr = altQ[0];
  assign mfSel  = altQ[2:1];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdQ[ch] <= '0; enQ[ch] <= '0; auxQ[ch] <= '0;
        dlQ[ch] <= '0; dhQ[ch] <= '0; lineQ[ch] <= '0; mdmQ[ch] <= '0;
      end else begin
        if (strb.wrHold[ch])   holdQ[ch] <= wrData;
        if (strb.wrEnable[ch]) enQ[ch]   <= wrData;
        if (strb.wrAux[ch])    auxQ[ch]  <= wrData;
        if (strb.wrDivLo[ch])  dlQ[ch]   <= wrData;
        if (strb.wrDivHi[ch])  dhQ[ch]   <= wrData;
        if (strb.wrLine[ch])   lineQ[ch] <= wrData;
        if (strb.wrMdm[ch])    mdmQ[ch]  <= wrData;
      end
    end

    always_comb begin
      unique case (mfSel)
        MF_OP2:   mfOut[ch] = op2N[ch];
        MF_BAUD:  mfOut[ch] = baudOutN[ch];
        MF_RXRDY: mfOut[ch] = rxRdyN[ch];
        default:  mfOut[ch] = 1'b1;
      endcase
    end

    assign dtrN[ch] = ~mdmQ[ch][0];
    assign rtsN[ch] = ~mdmQ[ch][1];
    assign dlab[ch] = lineQ[ch][DW-1];
    assign lineCtrl[ch*DW +: DW]   = lineQ[ch];
    assign holdReg[ch*DW +: DW]    = holdQ[ch];
    assign enableReg[ch*DW +: DW]  = enQ[ch];
    assign auxReg[ch*DW +: DW]     = auxQ[ch];
    assign divisor[ch*2*DW +: 2*DW] = {dhQ[ch], dlQ[ch]};
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_HOLD:   rdMux = holdQ[strb.rdCh];
      RD_ENABLE: rdMux = enQ[strb.rdCh];
      RD_AUX:    rdMux = auxQ[strb.rdCh];
      RD_DIVLO:  rdMux = dlQ[strb.rdCh];
      RD_DIVHI:  rdMux = dhQ[strb.rdCh];
      RD_ALT:    rdMux = {{(DW-ALT_W){1'b0}}, altQ};
      RD_LINE:   rdMux = lineQ[strb.rdCh];
      RD_MDM:    rdMux = mdmQ[strb.rdCh];
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (strb.rdStb) rdData <= rdMux;
  end
endmodule

// File: rtl/dual_uart_regbank.sv
module dual_uart_regbank
  import dual_uart_regbank_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  chSel,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [DW-1:0]         wrData,
  output logic [DW-1:0]         rdData,
  input  logic [NUM_CH-1:0]     op2N,
  input  logic [NUM_CH-1:0]     baudOutN,
  input  logic [NUM_CH-1:0]     rxRdyN,
  output logic [NUM_CH-1:0]     mfOut,
  output logic [NUM_CH-1:0]     dtrN,
  output logic [NUM_CH-1:0]     rtsN,
  output logic [NUM_CH*DW-1:0]  lineCtrl,
  output logic [NUM_CH*2*DW-1:0] divisor,
  output logic [NUM_CH*DW-1:0]  holdReg,
  output logic [NUM_CH*DW-1:0]  enableReg,
  output logic [NUM_CH*DW-1:0]  auxReg
);
  strobeT            strb;
  logic              concWr;
  logic [1:0]        mfSel;
  logic [NUM_CH-1:0] dlab;

  dual_uart_regbank_ctrl u_ctrl (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .chSel(chSel),
    .concWr(concWr), .dlab(dlab), .strb(strb)
  );

  dual_uart_regbank_dp #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .op2N(op2N), .baudOutN(baudOutN), .rxRdyN(rxRdyN),
    .rdData(rdData), .mfOut(mfOut), .dtrN(dtrN), .rtsN(rtsN),
    .lineCtrl(lineCtrl), .divisor(divisor), .holdReg(holdReg),
    .enableReg(enableReg), .auxReg(auxReg),
    .concWr(concWr), .mfSel(mfSel), .dlab(dlab)
  );
endmodule

// File: rtl/dual_uart_regbank_chk.sv
module dual_uart_regbank_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          chSel,
  input logic [2:0]    addr,
  input logic          wrEn,
  input logic          rdEn,
  input logic [DW-1:0] wrData,
  input logic [DW-1:0] rdData,
  input logic [1:0]    op2N,
  input logic [1:0]    mfOut,
  input logic [1:0]    dtrN,
  input logic [2*DW-1:0] lineCtrl,
  input logic          concWr,
  input logic [1:0]    mfSel
);
  logic selDlab;
  assign selDlab = chSel ? lineCtrl[2*DW-1] : lineCtrl[DW-1];

  // R11: read data changes only on a read strobe
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  // R3: a concurrent line-control write reaches both channels
  p_conc_both_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && concWr && addr == 3'd3) |=>
      (lineCtrl[DW-1:0] == $past(wrData)) && (lineCtrl[2*DW-1:DW] == $past(wrData)));

  // R2: a single-channel write to A leaves B untouched
  p_solo_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !concWr && addr == 3'd3 && !chSel) |=> $stable(lineCtrl[2*DW-1:DW]));

  // R8: default encoding routes the general output source
  p_mf_default_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mfSel == 2'b00) |-> (mfOut == op2N));

  // R8: reserved encoding holds the pins inactive
  p_mf_reserved_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mfSel == 2'b11) |-> (mfOut == 2'b11));

  // R9: reserved alternate-function bits read back as zero
  p_alt_rsvd_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 3'd2 && selDlab) |=> (rdData[DW-1:3] == '0));

  // R10: DTR of channel A falls only after a modem-control write with bit 0 set
  p_dtr_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dtrN[0]) |-> ($past(wrEn) && $past(addr) == 3'd4 && $past(wrData[0])));
endmodule

bind dual_uart_regbank dual_uart_regbank_chk #(.DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .chSel(chSel), .addr(addr), .wrEn(wrEn),
  .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .op2N(op2N),
  .mfOut(mfOut), .dtrN(dtrN), .lineCtrl(lineCtrl),
  .concWr(concWr), .mfSel(mfSel)
);

// File: tb/tb_dual_uart_regbank.sv
module tb_dual_uart_regbank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chSel = 1'b0;
  logic [2:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [1:0]  op2N = 2'b10;
  logic [1:0]  baudOutN = 2'b01;
  logic [1:0]  rxRdyN = 2'b00;
  logic [1:0]  mfOut, dtrN, rtsN;
  logic [15:0] lineCtrl, holdReg, enableReg, auxReg;
  logic [31:0] divisor;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_uart_regbank #(.DW(8)) dut (
    .clk(clk), .rstN(rstN), .chSel(chSel), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .op2N(op2N),
    .baudOutN(baudOutN), .rxRdyN(rxRdyN), .mfOut(mfOut), .dtrN(dtrN),
    .rtsN(rtsN), .lineCtrl(lineCtrl), .divisor(divisor), .holdReg(holdReg),
    .enableReg(enableReg), .auxReg(auxReg)
  );

  // {isRead, ch, addr, data-or-expected, requirement}
  localparam int NV = 35;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0,1'b0,3'd0,8'h11,4'd2}, {1'b0,1'b1,3'd0,8'h22,4'd2},
    {1'b1,1'b0,3'd0,8'h11,4'd2}, {1'b1,1'b1,3'd0,8'h22,4'd2},   // R2
    {1'b0,1'b0,3'd3,8'h80,4'd6}, {1'b0,1'b0,3'd0,8'h34,4'd6},
    {1'b0,1'b0,3'd1,8'h12,4'd6}, {1'b1,1'b0,3'd0,8'h34,4'd6},   // R6
    {1'b1,1'b0,3'd1,8'h12,4'd6}, {1'b0,1'b0,3'd3,8'h00,4'd6},
    {1'b1,1'b0,3'd0,8'h11,4'd6},
    {1'b0,1'b0,3'd3,8'h80,4'd4}, {1'b0,1'b0,3'd2,8'hFF,4'd4},   // R4 set via A
    {1'b1,1'b0,3'd2,8'h07,4'd9},                                // R9
    {1'b0,1'b1,3'd1,8'h5A,4'd7}, {1'b1,1'b0,3'd1,8'h5A,4'd7},   // R7
    {1'b0,1'b0,3'd3,8'h00,4'd3}, {1'b1,1'b1,3'd1,8'h5A,4'd7},
    {1'b0,1'b1,3'd0,8'h77,4'd3}, {1'b1,1'b0,3'd0,8'h77,4'd3},   // R3
    {1'b1,1'b1,3'd0,8'h77,4'd3},
    {1'b1,1'b0,3'd1,8'h00,4'd5}, {1'b1,1'b1,3'd1,8'h5A,4'd5},   // R5
    {1'b0,1'b1,3'd3,8'h80,4'd3}, {1'b0,1'b1,3'd2,8'h02,4'd4},   // R4 clear via B
    {1'b0,1'b0,3'd3,8'h00,4'd2}, {1'b1,1'b1,3'd2,8'h02,4'd4},
    {1'b0,1'b0,3'd0,8'h99,4'd2}, {1'b1,1'b1,3'd3,8'h80,4'd2},
    {1'b1,1'b1,3'd0,8'h00,4'd2}, {1'b0,1'b1,3'd3,8'h00,4'd2},
    {1'b1,1'b1,3'd0,8'h77,4'd2}, {1'b1,1'b0,3'd0,8'h99,4'd2},
    {1'b0,1'b0,3'd6,8'hAB,4'd11}, {1'b1,1'b0,3'd6,8'h00,4'd11}  // R11
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic ch, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    chSel = ch; addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic ch, input logic [2:0] a, output logic [7:0] val);
    @(negedge clk);
    chSel = ch; addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    val = rdData;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(1, rdData, 0, "rdData at reset");
    check(1, {dtrN, rtsN}, 4'b1111, "dtr/rts at reset");
    check(1, mfOut, op2N, "mf at reset");
    check(1, {lineCtrl, holdReg}, 0, "regs at reset");
    check(1, divisor, 0, "divisor at reset");
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) begin
        doRead(VEC[i][15], VEC[i][14:12], rv);
        check(int'(VEC[i][3:0]), rv, VEC[i][11:4], $sformatf("vector %0d", i));
      end else begin
        doWrite(VEC[i][15], VEC[i][14:12], VEC[i][11:4]);
      end
    end

    // R6 divisor bytes seen at the port: A high 5A, low 34
    check(6, divisor[15:0], 16'h5A34, "divisor A");

    // R8 multifunction routing; alternate register holds 02 (baud)
    @(negedge clk);
    check(8, mfOut, baudOutN, "mf baud select");
    doWrite(1'b0, 3'd3, 8'h80);
    doWrite(1'b0, 3'd2, 8'h04);
    @(negedge clk);
    check(8, mfOut, rxRdyN, "mf rxrdy select");
    doWrite(1'b0, 3'd2, 8'h06);
    @(negedge clk);
    check(8, mfOut, 2'b11, "mf reserved select");
    doWrite(1'b0, 3'd2, 8'h00);
    @(negedge clk);
    check(8, mfOut, op2N, "mf op2 select");
    // R9 reserved bits ignored
    doWrite(1'b0, 3'd2, 8'hF8);
    doRead(1'b0, 3'd2, rv);
    check(9, rv, 8'h00, "reserved bits write");
    check(9, mfOut, op2N, "mf after reserved write");
    doWrite(1'b0, 3'd3, 8'h00);

    // R10 inverted modem lines
    doWrite(1'b0, 3'd4, 8'h01);
    @(negedge clk);
    check(10, {dtrN, rtsN}, 4'b1011, "dtr A low");
    doWrite(1'b1, 3'd4, 8'h02);
    @(negedge clk);
    check(10, {dtrN, rtsN}, 4'b1001, "rts B low");

    // R11 read and write in one cycle return the old value (conc off)
    @(negedge clk);
    chSel = 1'b0; addr = 3'd0; wrData = 8'h42; wrEn = 1'b1; rdEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check(11, rdData, 8'h99, "read during write");
    repeat (2) @(negedge clk);
    check(11, rdData, 8'h99, "rdData held while idle");
    doRead(1'b0, 3'd0, rv);
    check(11, rv, 8'h42, "read after write");

    // R5 and R3 concurrent write with simultaneous read of B
    doWrite(1'b0, 3'd3, 8'h80);
    doWrite(1'b0, 3'd2, 8'h01);
    doWrite(1'b0, 3'd3, 8'h00);  // concurrent: both line regs cleared
    @(negedge clk);
    chSel = 1'b1; addr = 3'd0; wrData = 8'hC3; wrEn = 1'b1; rdEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check(5, rdData, 8'h77, "read B during concurrent write");
    check(3, holdReg, 16'hC3C3, "both hold regs after concurrent write");

    done = 1;
    finishRun();
  end
endmodule